// File: doc/BRIEF.md
# Serial Bus Slave Front End With Row-Wrapping Address Counter

This block is the two-wire serial bus slave for a small register and memory device. It samples the bus clock and data lines through synchronisers running on the system clock, recognises start, repeated start and stop conditions, and shifts bytes in and out most significant bit first. The slave answers to a 7-bit address whose upper four bits are fixed by a parameter (default `1010`) and whose lower three bits come from strap inputs. It drives the data line only low, through an open-drain enable.

Behind the bus it presents a plain byte interface to the storage it fronts. Write transactions load an internal 8-bit address counter from the first byte after the address and then issue one write strobe per data byte. The counter advances only in its low three bits on writes, so a burst stays inside one aligned 8-byte row. Read transactions carry no address byte: they fetch from wherever the counter stands and advance it over the whole 8-bit space. A busy input makes the slave refuse its own address, which lets a master poll for the end of a slow commit. A one-cycle stop pulse tells the storage that a write burst has ended and may now be committed.

Top module: `i2c_row_slave`

## Requirements
- R1: The slave acknowledges (drives `sda_oe_o` high during the 9th clock) an address byte whose upper seven bits equal `1010` followed by `strap_i[2:0]`, with bit 0 as the read flag (1 = read); any other address byte gets no acknowledge.
- R2: After an address byte that does not match, the slave acknowledges nothing and issues no write strobe until the next start condition.
- R3: In a write transaction the byte after the address byte loads the address counter, and every further byte produces a single-cycle `wr_en_o` pulse with `wr_addr_o` equal to the counter and `wr_data_o` equal to the byte, after which the counter advances; each such byte is acknowledged.
- R4: On writes the counter advances only in bits [2:0], so after address `8k+7` the next write goes to `8k`.
- R5: A read transaction starts at the current counter value; each byte is fetched with a single-cycle `rd_req_o` pulse at `rd_addr_o`, `rd_data_i` is taken in the cycle after the pulse, the byte is sent most significant bit first, and the counter then advances over all 8 bits, wrapping from FFh to 00h.
- R6: During a read, a master acknowledge (data low on the 9th clock) makes the slave send the next byte; a not-acknowledge makes it release the data line and send nothing more until the next start or stop.
- R7: While `busy_i` is high when an address byte completes, the slave does not acknowledge even its own address, and that transaction has no effect.
- R8: The slave changes `sda_oe_o` only while the bus clock is low; data written by the master is taken on the rising bus clock edge.
- R9: `stop_o` is a single-cycle pulse issued only when a stop condition ends a write transaction to this slave that carried at least one data byte.
- R10: A start or stop condition aborts any byte in progress; a repeated start begins a new transaction at the address byte.
- R11: After reset `sda_oe_o`, `wr_en_o`, `rd_req_o` and `stop_o` are low, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Low three bits of the slave address |
| busy_i | input | 1 | Storage is committing; refuse own address |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 8 | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_req_o` |
| stop_o | output | 1 | One-cycle pulse at the end of a write burst |

## Verification
The bound checker watches, on every cycle, that the open-drain enable moves only while the raw bus clock is low and that the write, read and stop strobes are single-cycle and mutually exclusive. Address matching against every 7-bit address and every strap setting, row wrapping on writes, full-range wrapping on reads, reads resuming from the counter, busy refusal, the silence after a mismatch or a not-acknowledge, and the abort of half-sent bytes depend on whole transactions, so only the bench's scenarios show them, against a storage model and expected contents it computes itself.

// File: rtl/i2c_row_pkg.sv
package i2c_row_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int ID_W    = 7 - STRAP_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_IGNORE
  } st_e;

  typedef enum logic [1:0] {
    RX_ADDR, RX_REG, RX_DATA
  } rx_e;
endpackage

// File: rtl/i2c_row_sync.sv
module i2c_row_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_o;
    end
  end

  assign scl_s   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
  assign start_o = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_row_ctr.sv
module i2c_row_ctr #(
  parameter int AW    = 8,
  parameter int ROW_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_row_i,
  input  logic          inc_lin_i,
  output logic [AW-1:0] addr_o
);
  logic [ROW_W-1:0] low_nxt;
  assign low_nxt = addr_o[ROW_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_o <= '0;
    else if (ld_i)      addr_o <= ld_val_i;
    else if (inc_row_i) addr_o <= {addr_o[AW-1:ROW_W], low_nxt};
    else if (inc_lin_i) addr_o <= addr_o + 1'b1;
  end
endmodule

// File: rtl/i2c_row_slave.sv
module i2c_row_slave
  import i2c_row_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID      = 4'b1010,
  parameter int              ROW_W       = 3,
  parameter int              SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               wr_en_o,
  output logic [BYTE_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_req_o,
  output logic [BYTE_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               stop_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic sda_s, rise, fall, start_c, stop_c;
  st_e  st;
  rx_e  kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txreg, ctr, ld_val;
  logic is_rd, rd_pend, data_seen, ld, inc_row, inc_lin;

  i2c_row_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_row_ctr #(.AW(BYTE_W), .ROW_W(ROW_W)) u_ctr (
    .clk_i, .rst_ni, .ld_i(ld), .ld_val_i(ld_val),
    .inc_row_i(inc_row), .inc_lin_i(inc_lin), .addr_o(ctr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;  kind <= RX_ADDR;  cnt <= '0;
      shreg <= '0;  txreg <= '0;  ld_val <= '0;
      is_rd <= 1'b0;  rd_pend <= 1'b0;  data_seen <= 1'b0;
      ld <= 1'b0;  inc_row <= 1'b0;  inc_lin <= 1'b0;
      sda_oe_o <= 1'b0;  wr_en_o <= 1'b0;  rd_req_o <= 1'b0;  stop_o <= 1'b0;
      wr_addr_o <= '0;  wr_data_o <= '0;  rd_addr_o <= '0;
    end else begin
      wr_en_o <= 1'b0;  rd_req_o <= 1'b0;  stop_o <= 1'b0;
      ld <= 1'b0;  inc_row <= 1'b0;  inc_lin <= 1'b0;
      rd_pend <= rd_req_o;
      if (rd_pend) txreg <= rd_data_i;  // fetch lands one cycle after the request

      if (start_c) begin
        st <= ST_RX;  kind <= RX_ADDR;  cnt <= '0;
        sda_oe_o <= 1'b0;  data_seen <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE;  sda_oe_o <= 1'b0;
        stop_o <= data_seen;  data_seen <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (fall && cnt == CNT_W'(BYTE_W)) begin
              cnt <= '0;
              st  <= ST_RXACK;
              unique case (kind)
                RX_ADDR: begin
                  if (shreg[BYTE_W-1:1] == {DEV_ID, strap_i} && !busy_i) begin
                    sda_oe_o <= 1'b1;
                    is_rd    <= shreg[0];
                    if (shreg[0]) begin
                      rd_req_o  <= 1'b1;
                      rd_addr_o <= ctr;
                    end
                  end else begin
                    st <= ST_IGNORE;
                  end
                end
                RX_REG: begin
                  sda_oe_o <= 1'b1;
                  ld       <= 1'b1;
                  ld_val   <= shreg;
                end
                default: begin
                  sda_oe_o  <= 1'b1;
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ctr;
                  wr_data_o <= shreg;
                  inc_row   <= 1'b1;
                  data_seen <= 1'b1;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (fall) begin
              if (is_rd) begin
                st       <= ST_TX;
                sda_oe_o <= ~txreg[BYTE_W-1];
              end else begin
                st       <= ST_RX;
                sda_oe_o <= 1'b0;
                kind     <= (kind == RX_ADDR) ? RX_REG : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (fall) begin
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                cnt      <= '0;
                st       <= ST_TXACK;
                sda_oe_o <= 1'b0;
                inc_lin  <= 1'b1;
              end else begin
                cnt      <= cnt + 1'b1;
                txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~txreg[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (rise) begin
              if (sda_s) begin
                st <= ST_IGNORE;
              end else begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= ctr;
              end
            end else if (fall) begin
              st       <= ST_TX;
              sda_oe_o <= ~txreg[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_row_slave_chk.sv
module i2c_row_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_en_o,
  input logic rd_req_o,
  input logic stop_o
);
  // R8
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R9
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, rd_req_o, stop_o}));
endmodule

bind i2c_row_slave i2c_row_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wr_en_o(wr_en_o), .rd_req_o(rd_req_o), .stop_o(stop_o)
);

// File: tb/i2c_row_slave_test.sv
`timescale 1ns/1ps
module i2c_row_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'd0;
  logic sda_oe, wr_en, rd_req, stop_p;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_bus;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:255];
  logic [7:0] exp_m [0:255];
  logic [7:0] log_a [0:255];
  logic [7:0] log_d [0:255];
  int log_n = 0, stop_n = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_row_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .busy_i(busy), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .stop_o(stop_p)
  );

  // storage model with one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      rd_data <= 8'h00;
    end else begin
      if (wr_en) begin
        mem[wr_addr] <= wr_data;
        log_a[log_n & 255] <= wr_addr;
        log_d[log_n & 255] <= wr_data;
        log_n <= log_n + 1;
      end
      if (rd_req) rd_data <= mem[rd_addr];
      if (stop_p) stop_n <= stop_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(Q); m_sda = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack_n);
    send_bits(b, 8);
    tick(Q); m_sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack_n = sda_bus;
    tick(Q); scl = 1'b0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2*Q); scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q); scl = 1'b0;
    end
    tick(Q); m_sda = nack; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; m_sda = 1'b1;
  endtask

  // write burst: address byte, start address, data bytes
  task automatic wburst(input logic [7:0] base, input int n, input logic [7:0] seed);
    logic a;
    int l0;
    logic [7:0] ea;
    l0 = log_n;
    bstart();
    wbyte({4'b1010, strap, 1'b0}, a); check(a == 1'b0, "R1", a, 0);
    wbyte(base, a);                    check(a == 1'b0, "R3", a, 0);
    for (int k = 0; k < n; k++) begin
      wbyte(seed + 8'(k), a);          check(a == 1'b0, "R3", a, 0);
      ea = {base[7:3], 3'(base[2:0] + 3'(k))};
      exp_m[ea] = seed + 8'(k);
    end
    bstop(); tick(4);
    check(log_n - l0 == n, "R3", log_n - l0, n);
    for (int k = 0; k < n; k++) begin
      ea = {base[7:3], 3'(base[2:0] + 3'(k))};
      check(log_a[(l0 + k) & 255] == ea, "R4", log_a[(l0 + k) & 255], ea);
      check(log_d[(l0 + k) & 255] == seed + 8'(k), "R3", log_d[(l0 + k) & 255], seed + 8'(k));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 190000 cycles expected completion sooner");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    int l0, s0;
    logic [7:0] ex;
    for (int i = 0; i < 256; i++) exp_m[i] = 8'(i) ^ 8'h5A;

    tick(5);
    // R11 reset state
    check(sda_oe == 1'b0, "R11", sda_oe, 0);
    check({wr_en, rd_req, stop_p} == 3'b000, "R11", {wr_en, rd_req, stop_p}, 0);
    rst_n = 1'b1; tick(5);

    // R1 every 7-bit address with a fixed strap
    strap = 3'b101;
    l0 = log_n; s0 = stop_n;
    for (int ad = 0; ad < 128; ad++) begin
      bstart(); wbyte({7'(ad), 1'b0}, a); bstop();
      ex = (ad == 7'b1010101) ? 8'd0 : 8'd1;
      check(a == ex[0], "R1", a, ex);
    end
    // R1 every strap against every low-address field
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int t = 0; t < 8; t++) begin
        bstart(); wbyte({4'b1010, 3'(t), 1'b0}, a); bstop();
        ex = (s == t) ? 8'd0 : 8'd1;
        check(a == ex[0], "R1", a, ex);
      end
    end
    check(log_n == l0, "R2", log_n - l0, 0);
    check(stop_n == s0, "R9", stop_n - s0, 0);

    // R2 mismatched address: later bytes ignored
    strap = 3'd0;
    l0 = log_n; s0 = stop_n;
    bstart();
    wbyte(8'hA2, a); check(a == 1'b1, "R2", a, 1);
    wbyte(8'h10, a); check(a == 1'b1, "R2", a, 1);
    wbyte(8'h77, a); check(a == 1'b1, "R2", a, 1);
    bstop(); tick(4);
    check(log_n == l0, "R2", log_n - l0, 0);
    check(stop_n == s0, "R9", stop_n - s0, 0);

    // R7 busy refuses own address
    busy = 1'b1;
    bstart();
    wbyte(8'hA0, a); check(a == 1'b1, "R7", a, 1);
    wbyte(8'h20, a); check(a == 1'b1, "R7", a, 1);
    wbyte(8'h33, a); check(a == 1'b1, "R7", a, 1);
    bstop(); tick(4);
    busy = 1'b0;
    check(log_n == l0, "R7", log_n - l0, 0);

    // R3 R4 ten bytes from 3Dh wrap inside row 38h
    s0 = stop_n;
    wburst(8'h3D, 10, 8'hC0);
    check(stop_n == s0 + 1, "R9", stop_n - s0, 1);
    // R4 boundary at row 0
    s0 = stop_n;
    wburst(8'h07, 2, 8'h90);
    check(stop_n == s0 + 1, "R9", stop_n - s0, 1);

    // R5 set counter with address-only write, repeated start, read
    l0 = log_n; s0 = stop_n;
    bstart();
    wbyte(8'hA0, a); wbyte(8'h3E, a);
    bstart();
    wbyte(8'hA1, a); check(a == 1'b0, "R1", a, 0);
    rbyte(1'b0, b); check(b == exp_m[8'h3E], "R5", b, exp_m[8'h3E]);
    rbyte(1'b0, b); check(b == exp_m[8'h3F], "R5", b, exp_m[8'h3F]);
    rbyte(1'b1, b); check(b == exp_m[8'h40], "R6", b, exp_m[8'h40]);
    // R6 after not-acknowledge the line stays released
    tick(3);
    check(sda_oe == 1'b0, "R6", sda_oe, 0);
    rbyte(1'b1, b); check(b == 8'hFF, "R6", b, 8'hFF);
    bstop(); tick(4);
    check(stop_n == s0, "R9", stop_n - s0, 0);
    check(log_n == l0, "R5", log_n - l0, 0);

    // R5 read resumes at the counter left behind (41h)
    bstart();
    wbyte(8'hA1, a); check(a == 1'b0, "R5", a, 0);
    rbyte(1'b1, b); check(b == exp_m[8'h41], "R5", b, exp_m[8'h41]);
    bstop();

    // R5 read crosses FFh to 00h
    bstart();
    wbyte(8'hA0, a); wbyte(8'hFE, a);
    bstart();
    wbyte(8'hA1, a);
    rbyte(1'b0, b); check(b == exp_m[8'hFE], "R5", b, exp_m[8'hFE]);
    rbyte(1'b0, b); check(b == exp_m[8'hFF], "R5", b, exp_m[8'hFF]);
    rbyte(1'b1, b); check(b == exp_m[8'h00], "R5", b, exp_m[8'h00]);
    bstop();

    // R10 start aborts a half-sent byte
    l0 = log_n;
    bstart(); send_bits(8'hA0, 4);
    bstart();
    wbyte(8'hA0, a); check(a == 1'b0, "R10", a, 0);
    wbyte(8'h50, a); wbyte(8'h99, a);
    bstop(); tick(4);
    check(log_n == l0 + 1, "R10", log_n - l0, 1);
    check(log_a[l0 & 255] == 8'h50, "R10", log_a[l0 & 255], 8'h50);
    check(log_d[l0 & 255] == 8'h99, "R10", log_d[l0 & 255], 8'h99);
    // R10 stop aborts a half-sent byte, next transaction is normal
    l0 = log_n;
    bstart(); wbyte(8'hA0, a); send_bits(8'h12, 3); bstop();
    check(log_n == l0, "R10", log_n - l0, 0);
    bstart(); wbyte(8'hA0, a); check(a == 1'b0, "R10", a, 0);
    bstop();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule